// File: doc/BRIEF.md
# Stepped Stereo Attenuator with Master Mute

This block scales a 16-bit two's-complement stereo playback stream by a per-channel attenuation between 0 dB and 64 dB. The two channels each keep a requested target level and an applied level. The applied level moves one 1 dB step toward its target on each pulse of the audio-rate sample strobe, so a level change becomes a short ramp and not a jump. The attenuation itself is a multiply by an unsigned Q1.15 gain. The gains form a 65-entry table that is computed when the design is elaborated.

A control agent sends requests as single-cycle strobes. Each request carries a channel code, an attenuation value and a mute value. Volume can only be set per channel, and mute can only be set on the master channel. A request of an unsupported kind raises a one-cycle stall flag and changes nothing. While mute is on, both outputs are zero, but the applied levels are kept.

Each channel has a small ramp state machine with three states. RS_HOLD means the applied level equals the target. RS_DEEPEN means the target is deeper, so the applied level rises by one per strobe. RS_LIFT means the target is shallower, so the applied level falls by one per strobe. After every clock the state is recomputed from the next target and the next applied level. The machine therefore moves between any two states in one cycle: to RS_HOLD when the two become equal, and to RS_DEEPEN or RS_LIFT by the sign of the target minus the applied level.

Top module: `stepvol_top`

## Requirements
- R1: The gain for attenuation k (0..64) is G(0)=32768 and G(k)=floor((G(k-1)*58409+32768)/65536). The output sample is floor((x*G+16384)/32768), saturated to the signed 16-bit range.
- R2: On each cycle with smp_tick high, the applied level of a channel moves by exactly 1 toward its target. When the applied level equals the target it does not change. Without smp_tick it never changes.
- R3: Channel code 2'b01 selects left and 2'b10 selects right. Each channel holds its own target and applied level, and a request to one channel does not affect the other.
- R4: A volume request with channel code 2'b00 (master) or 2'b11 raises stall in the next cycle and leaves both levels unchanged.
- R5: A mute request with channel code 2'b00 sets the mute state to mute_val and does not raise stall.
- R6: A mute request with any channel code other than 2'b00 raises stall in the next cycle and leaves the mute state unchanged.
- R7: While mute is on, both outputs are zero. The applied levels are retained, so after unmuting the outputs resume at the previous attenuation.
- R8: A target written during a ramp sets the direction of the next step by the sign of target minus applied level. A target written in the same cycle as a smp_tick does not affect that cycle's step.
- R9: After reset both channels are at 0 dB, mute is off, stall is low and both outputs are zero.
- R10: A requested attenuation above 64 is treated as 64.
- R11: The outputs are registered and reflect the inputs and the applied level with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_tick | input | 1 | Audio-rate step strobe |
| vol_req | input | 1 | Volume request strobe |
| mute_req | input | 1 | Mute request strobe |
| req_chan | input | 2 | Channel code: 00 master, 01 left, 10 right |
| req_att | input | 7 | Requested attenuation in dB |
| mute_val | input | 1 | Mute value carried by a mute request |
| in_l | input | 16 | Left input sample, signed |
| in_r | input | 16 | Right input sample, signed |
| out_l | output | 16 | Left attenuated sample, signed |
| out_r | output | 16 | Right attenuated sample, signed |
| stall | output | 1 | One-cycle flag for an unsupported request |

## Verification
A target write and a step strobe can land on the same clock edge. In that case the step must follow the state that was already registered, not the target that is arriving. The bench provokes this by raising vol_req and smp_tick in the same cycle while a channel sits in RS_HOLD. It then expects the applied level to stay unchanged for that strobe and to move one step on the next strobe. A second case reverses the target mid-ramp, and the bench judges the direction of each following step from a level model that it keeps itself.

// File: rtl/stepvol_pkg.sv
package stepvol_pkg;

    typedef enum logic [1:0] {
        RS_HOLD   = 2'd0,
        RS_DEEPEN = 2'd1,
        RS_LIFT   = 2'd2
    } ramp_state_t;

    localparam logic [1:0] CH_MASTER = 2'b00;
    localparam logic [1:0] CH_LEFT   = 2'b01;
    localparam logic [1:0] CH_RIGHT  = 2'b10;

    // Gain for k dB: repeated multiply by 10^(-1/20) in Q0.16 with rounding.
    function automatic longint unsigned gain_of(input int k, input int frac, input int ratio_q16);
        longint unsigned g;
        g = 64'd1 << frac;
        for (int i = 0; i < k; i++) begin
            g = (g * longint'(ratio_q16) + 64'd32768) >> 16;
        end
        return g;
    endfunction

endpackage

// File: rtl/vol_gain_rom.sv
module vol_gain_rom #(
    parameter int ATT_MAX   = 64,
    parameter int GW        = 16,
    parameter int FRAC      = 15,
    parameter int RATIO_Q16 = 58409,
    localparam int LW       = $clog2(ATT_MAX + 1)
) (
    input  logic [LW-1:0] idx,
    output logic [GW-1:0] gain
);
    import stepvol_pkg::*;

    logic [GW-1:0] tab [ATT_MAX+1];

    for (genvar k = 0; k <= ATT_MAX; k++) begin : g_rom
        assign tab[k] = GW'(gain_of(k, FRAC, RATIO_Q16));
    end

    always_comb begin
        gain = '0;
        for (int k = 0; k <= ATT_MAX; k++) begin
            if (idx == LW'(k)) gain = tab[k];
        end
    end
endmodule

// File: rtl/vol_scale.sv
module vol_scale #(
    parameter int DW   = 16,
    parameter int GW   = 16,
    parameter int FRAC = 15
) (
    input  logic signed [DW-1:0] x,
    input  logic        [GW-1:0] g,
    output logic signed [DW-1:0] y
);
    localparam int PW = DW + GW + 1;
    localparam logic signed [PW-1:0] RND  = PW'(64'd1 << (FRAC - 1));
    localparam logic signed [PW-1:0] MAXV = PW'((64'd1 << (DW - 1)) - 64'd1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [PW-1:0] xe, ge, prod, shifted;

    always_comb begin
        xe      = $signed({{(GW + 1){x[DW-1]}}, x});
        ge      = $signed({{(DW + 1){1'b0}}, g});
        prod    = xe * ge;
        shifted = (prod + RND) >>> FRAC;
        if (shifted > MAXV)      y = MAXV[DW-1:0];
        else if (shifted < MINV) y = MINV[DW-1:0];
        else                     y = shifted[DW-1:0];
    end
endmodule

// File: rtl/vol_ramp.sv
module vol_ramp #(
    parameter int ATT_MAX = 64,
    localparam int LW     = $clog2(ATT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr,
    input  logic [LW-1:0] wr_lvl,
    output logic [LW-1:0] lvl
);
    import stepvol_pkg::*;

    ramp_state_t   st_q, st_n;
    logic [LW-1:0] tgt_q, tgt_n, cur_q, cur_n;

    always_comb begin
        cur_n = cur_q;
        if (tick) begin
            unique case (st_q)
                RS_HOLD:   cur_n = cur_q;
                RS_DEEPEN: cur_n = cur_q + 1'b1;
                RS_LIFT:   cur_n = cur_q - 1'b1;
                default:   cur_n = cur_q;
            endcase
        end
        tgt_n = wr ? wr_lvl : tgt_q;
        if (tgt_n > cur_n)      st_n = RS_DEEPEN;
        else if (tgt_n < cur_n) st_n = RS_LIFT;
        else                    st_n = RS_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RS_HOLD;
            tgt_q <= '0;
            cur_q <= '0;
        end else begin
            st_q  <= st_n;
            tgt_q <= tgt_n;
            cur_q <= cur_n;
        end
    end

    always_comb lvl = cur_q;

    p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q <= LW'(ATT_MAX)) && (tgt_q <= LW'(ATT_MAX)));
    p_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cur_q));
    p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cur_q == $past(cur_q)) || (cur_q == $past(cur_q) + 1'b1)
                 || (cur_q + 1'b1 == $past(cur_q)));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_HOLD && tick) |=> $stable(cur_q));
endmodule

// File: rtl/stepvol_top.sv
module stepvol_top #(
    parameter int ATT_MAX   = 64,
    parameter int REQ_W     = 7,
    parameter int DW        = 16,
    parameter int GW        = 16,
    parameter int FRAC      = 15,
    parameter int RATIO_Q16 = 58409
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_tick,
    input  logic                 vol_req,
    input  logic                 mute_req,
    input  logic [1:0]           req_chan,
    input  logic [REQ_W-1:0]     req_att,
    input  logic                 mute_val,
    input  logic signed [DW-1:0] in_l,
    input  logic signed [DW-1:0] in_r,
    output logic signed [DW-1:0] out_l,
    output logic signed [DW-1:0] out_r,
    output logic                 stall
);
    import stepvol_pkg::*;

    localparam int LW = $clog2(ATT_MAX + 1);

    logic [LW-1:0]        att_clamped;
    logic                 mute_q, stall_q;
    logic                 vol_bad, mute_bad, mute_ok;
    logic signed [DW-1:0] din [2];
    logic signed [DW-1:0] scaled [2];

    always_comb begin
        if (req_att > REQ_W'(ATT_MAX)) att_clamped = LW'(ATT_MAX);
        else                           att_clamped = req_att[LW-1:0];
        vol_bad  = vol_req && (req_chan != CH_LEFT) && (req_chan != CH_RIGHT);
        mute_bad = mute_req && (req_chan != CH_MASTER);
        mute_ok  = mute_req && (req_chan == CH_MASTER);
        din[0]   = in_l;
        din[1]   = in_r;
    end

    for (genvar c = 0; c < 2; c++) begin : g_ch
        localparam logic [1:0] MY_CH = (c == 0) ? CH_LEFT : CH_RIGHT;
        logic [LW-1:0] lvl;
        logic [GW-1:0] gain;
        logic          wr;

        assign wr = vol_req && (req_chan == MY_CH);

        vol_ramp #(.ATT_MAX(ATT_MAX)) u_ramp (
            .clk(clk), .rst_n(rst_n), .tick(smp_tick),
            .wr(wr), .wr_lvl(att_clamped), .lvl(lvl)
        );
        vol_gain_rom #(.ATT_MAX(ATT_MAX), .GW(GW), .FRAC(FRAC), .RATIO_Q16(RATIO_Q16)) u_rom (
            .idx(lvl), .gain(gain)
        );
        vol_scale #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_scale (
            .x(din[c]), .g(gain), .y(scaled[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mute_q  <= 1'b0;
            stall_q <= 1'b0;
        end else begin
            stall_q <= vol_bad || mute_bad;
            if (mute_ok) mute_q <= mute_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_l <= '0;
            out_r <= '0;
        end else begin
            out_l <= mute_q ? '0 : scaled[0];
            out_r <= mute_q ? '0 : scaled[1];
        end
    end

    assign stall = stall_q;

    p_stall_vol_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vol_req && (req_chan == CH_MASTER)) |=> stall);
    p_mute_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_req && req_chan == CH_MASTER && !vol_req) |=> !stall && (mute_q == $past(mute_val)));
    p_chmute_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_req && req_chan != CH_MASTER) |=> stall && $stable(mute_q));
    p_mute_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mute_q |=> (out_l == '0) && (out_r == '0));
endmodule

// File: tb/sim_stepvol_top.sv
module sim_stepvol_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_tick = 1'b0, vol_req = 1'b0, mute_req = 1'b0, mute_val = 1'b0;
    logic [1:0]         req_chan = 2'b00;
    logic [6:0]         req_att = '0;
    logic signed [15:0] in_l = '0, in_r = '0;
    logic signed [15:0] out_l, out_r;
    logic               stall;

    int      total = 0, bad = 0;
    bit      done = 0;
    longint  gtab [65];
    int      ml = 0, mr = 0, tl = 0, tr = 0;
    bit      muted = 0;

    always #5 clk = ~clk;

    stepvol_top u0 (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .vol_req(vol_req),
        .mute_req(mute_req), .req_chan(req_chan), .req_att(req_att),
        .mute_val(mute_val), .in_l(in_l), .in_r(in_r),
        .out_l(out_l), .out_r(out_r), .stall(stall)
    );

    function automatic longint scale(longint x, int lvl);
        longint p;
        p = (x * gtab[lvl] + 16384) >>> 15;
        if (p > 32767) p = 32767;
        if (p < -32768) p = -32768;
        return p;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_outs(string tag);
        @(negedge clk);
        chk({tag, " left"},  longint'(out_l), muted ? 0 : scale(longint'(in_l), ml));
        chk({tag, " right"}, longint'(out_r), muted ? 0 : scale(longint'(in_r), mr));
    endtask

    function automatic int step(int cur, int tgt);
        if (tgt > cur) return cur + 1;
        if (tgt < cur) return cur - 1;
        return cur;
    endfunction

    task automatic tick_n(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); smp_tick = 1'b1;
            @(negedge clk); smp_tick = 1'b0;
            ml = step(ml, tl);
            mr = step(mr, tr);
        end
    endtask

    task automatic send_vol(logic [1:0] ch, int lvl, output bit st);
        @(negedge clk); vol_req = 1'b1; req_chan = ch; req_att = 7'(lvl);
        @(negedge clk); vol_req = 1'b0; st = stall;
        if (ch == 2'b01) tl = (lvl > 64) ? 64 : lvl;
        if (ch == 2'b10) tr = (lvl > 64) ? 64 : lvl;
    endtask

    task automatic send_mute(logic [1:0] ch, bit v, output bit st);
        @(negedge clk); mute_req = 1'b1; req_chan = ch; mute_val = v;
        @(negedge clk); mute_req = 1'b0; st = stall;
        if (ch == 2'b00) muted = v;
    endtask

    initial begin
        bit st;
        longint pats [4];
        pats[0] = 32767; pats[1] = -32768; pats[2] = 12345; pats[3] = -1;
        gtab[0] = 32768;
        for (int k = 1; k <= 64; k++) gtab[k] = (gtab[k-1] * 58409 + 32768) >>> 16;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9 out_l after reset", longint'(out_l), 0);
        chk("R9 out_r after reset", longint'(out_r), 0);
        chk("R9 stall after reset", longint'(stall), 0);

        // R11: one-cycle latency at 0 dB
        in_l = 16'sd1000; in_r = -16'sd1000;
        @(negedge clk);
        chk("R11 out_l latency", longint'(out_l), 1000);
        chk("R11 out_r latency", longint'(out_r), -1000);

        // R2, R3: left ramp to 6 dB, right untouched
        send_vol(2'b01, 6, st);
        chk("R3 left write no stall", longint'(st), 0);
        for (int i = 0; i < 8; i++) begin
            tick_n(1);
            check_outs($sformatf("R2 R3 left ramp step %0d", i));
        end
        chk("R2 left settled level", longint'(ml), 6);

        // R1: right sweep through every level with varied samples
        send_vol(2'b10, 64, st);
        for (int i = 1; i <= 64; i++) begin
            in_r = 16'(pats[i % 4]);
            tick_n(1);
            check_outs($sformatf("R1 right level %0d", i));
        end
        in_r = 16'sd32767;
        check_outs("R1 right floor");

        // R10: clamp of oversized requests
        in_l = 16'sd32767;
        send_vol(2'b01, 100, st);
        tick_n(70);
        check_outs("R10 left clamped ramp");
        chk("R10 left model level", longint'(ml), 64);
        send_vol(2'b10, 127, st);
        tick_n(3);
        check_outs("R10 right stays at floor");

        // R4: master and reserved volume requests stall
        send_vol(2'b00, 0, st);
        chk("R4 master volume stall", longint'(st), 1);
        tick_n(3);
        check_outs("R4 levels unchanged after master volume");
        send_vol(2'b11, 0, st);
        chk("R4 reserved volume stall", longint'(st), 1);
        tick_n(2);
        check_outs("R4 levels unchanged after reserved code");

        // R8: reversal mid-ramp
        send_vol(2'b01, 60, st);
        tick_n(2);
        check_outs("R8 left ramp to 62");
        send_vol(2'b01, 63, st);
        tick_n(1);
        check_outs("R8 left reversed to 63");
        tick_n(1);
        check_outs("R8 left holds 63");

        // R8: target write and tick in the same cycle
        @(negedge clk); vol_req = 1'b1; req_chan = 2'b01; req_att = 7'd50; smp_tick = 1'b1;
        @(negedge clk); vol_req = 1'b0; smp_tick = 1'b0;
        ml = step(ml, tl); tl = 50;
        check_outs("R8 same-cycle write leaves level at 63");
        tick_n(1);
        check_outs("R8 next tick steps to 62");
        tick_n(12);
        check_outs("R2 left settles at 50");

        // R5, R7: master mute
        send_mute(2'b00, 1'b1, st);
        chk("R5 master mute no stall", longint'(st), 0);
        check_outs("R7 outputs zero while muted");
        tick_n(3);
        in_l = -16'sd20000; in_r = 16'sd30000;
        check_outs("R7 still zero with new samples");
        send_mute(2'b00, 1'b0, st);
        chk("R5 unmute no stall", longint'(st), 0);
        check_outs("R7 resume at prior levels");

        // R6: per-channel mute ignored
        send_mute(2'b01, 1'b1, st);
        chk("R6 left mute stall", longint'(st), 1);
        check_outs("R6 left mute ignored");
        send_mute(2'b10, 1'b1, st);
        chk("R6 right mute stall", longint'(st), 1);
        check_outs("R6 right mute ignored");
        @(negedge clk);
        chk("R6 stall is one cycle", longint'(stall), 0);

        // R3: ramp left back to 0 while right stays at 64
        send_vol(2'b01, 0, st);
        tick_n(50);
        in_l = -16'sd32768;
        check_outs("R3 left back to 0 dB, right at floor");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule